// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals and the once-per-turn reference pulse of an incremental encoder into a registered direction bit and a 16-bit up/down position count. The three inputs are first brought into the clock domain through a two-stage synchronizer. The block then compares each new sample of the phase pair with the one before it, which yields count pulses and a direction. A 3-bit mode field sets the behaviour. When its top bit is clear the block is idle. When the top bit is set, the middle bit selects double resolution (phase A edges only) or quadruple resolution (every edge of both phases). The low bit selects the reset source: clear on the reference pulse, or wrap at a programmable maximum count.

In the reference-pulse reset modes, the block watches for a count that lands outside the expected range. It raises a sticky flag that software clears, and it pulses an error interrupt unless that interrupt is masked. Counting continues after an error. Each valid reference pulse gives a one-cycle index interrupt, and the direction can drive an output pin when enabled.

Top module: `quad_pos_counter`

## Requirements
- R1: A single-phase change where phase A leads phase B ({A,B} sequence 00→10→11→01→00) sets dir_status to 1 and counts up. The reverse sequence sets dir_status to 0 and counts down.
- R2: With cfg_mode 110 or 111 (quadruple resolution), every edge of either phase moves the count by one.
- R3: With cfg_mode 100 or 101 (double resolution), only phase A edges move the count. A phase B edge leaves the count unchanged.
- R4: A sample where both phases changed at once is invalid. It does not change the count or dir_status.
- R5: When cfg_mode[2] is 0, the count holds and no index interrupt is produced.
- R6: In modes 100 and 110 with cfg_index_clear_en = 1, a rising reference pulse seen while both phases are low clears the count to 0. A reference pulse while a phase is high is ignored.
- R7: In modes 100 and 110 with cfg_index_clear_en = 0, a reference pulse does not clear the count, and the count wraps naturally from 0 down to 0xFFFF.
- R8: In modes 101 and 111, counting up from cfg_max_count loads 0, and counting down from 0 loads cfg_max_count.
- R9: In modes 100 and 110, an up count that lands on cfg_max_count+1, or a down count that lands on 0xFFFF, sets error_flag and pulses error_irq for one cycle, unless cfg_err_irq_mask is 1, in which case only the flag is set. Counting continues afterwards.
- R10: error_flag stays set until err_flag_clear is 1, and a clear takes effect at the next clock edge.
- R11: index_irq pulses for one cycle on each valid reference pulse in any active mode, whether or not the count is cleared. A counter wrap produces no index interrupt.
- R12: dir_out equals dir_status when cfg_dir_out_en is 1, and is 0 otherwise.
- R13: A phase or reference change applied at the inputs shows on pos_count, dir_status, index_irq and error_irq at the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_index | input | 1 | Encoder reference pulse, asynchronous |
| cfg_mode | input | 3 | Mode: 0xx idle, 100/101 double, 110/111 quadruple; low bit 1 = max-count wrap |
| cfg_max_count | input | 16 | Maximum count for wrap and error bound |
| cfg_index_clear_en | input | 1 | Clear count on reference pulse in reference modes |
| cfg_err_irq_mask | input | 1 | Suppress the error interrupt pulse |
| cfg_dir_out_en | input | 1 | Drive direction onto dir_out |
| err_flag_clear | input | 1 | Clear the sticky error flag |
| pos_count | output | 16 | Position count |
| dir_status | output | 1 | Direction, 1 = forward |
| dir_out | output | 1 | Gated direction pin |
| index_irq | output | 1 | One-cycle index interrupt |
| error_irq | output | 1 | One-cycle error interrupt |
| error_flag | output | 1 | Sticky position error flag |

## Verification
An input change needs two synchronizer stages, and the count register sits behind them. So pos_count, dir_status and both interrupt pulses change at the third rising edge after the stimulus, and the interrupts drop again one edge later. Every stimulus is applied on a falling edge. The bench samples the interrupt lines exactly three falling edges later, then waits one more falling edge before it checks the count or the flag. One test checks the count after two edges to confirm it has not yet moved. err_flag_clear and dir_out act without the synchronizer: the clear shows one edge after it is applied, and dir_out follows its enable combinationally.

// File: rtl/qpc_pkg.sv
`timescale 1ns/1ps
package qpc_pkg;
    localparam int MODE_W = 3;
    // mode field bit meaning
    localparam int MODE_ACTIVE_BIT = 2;
    localparam int MODE_X4_BIT     = 1;
    localparam int MODE_MAXWRAP_BIT = 0;

    typedef struct packed {
        logic active;
        logic x4;
        logic max_wrap;
        logic idx_mode;
    } mode_dec_t;

    function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] m);
        mode_dec_t r;
        r.active   = m[MODE_ACTIVE_BIT];
        r.x4       = m[MODE_X4_BIT];
        r.max_wrap = m[MODE_ACTIVE_BIT] & m[MODE_MAXWRAP_BIT];
        r.idx_mode = m[MODE_ACTIVE_BIT] & ~m[MODE_MAXWRAP_BIT];
        return r;
    endfunction
endpackage

// File: rtl/qpc_sync.sv
`timescale 1ns/1ps
module qpc_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_out
        assign sync_out[i] = st_q.s2[i];
    end
endmodule

// File: rtl/qpc_decode.sv
`timescale 1ns/1ps
module qpc_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic a_s,
    input  logic b_s,
    input  logic idx_s,
    input  logic active,
    input  logic x4,
    output logic cnt_pulse,
    output logic cnt_up,
    output logic idx_hit,
    output logic dir
);
    typedef struct packed {
        logic a;
        logic b;
        logic idx;
        logic dir;
    } dec_t;

    dec_t st_d, st_q;
    logic a_chg, b_chg, one_chg, up_c;

    always_comb begin
        a_chg   = a_s ^ st_q.a;
        b_chg   = b_s ^ st_q.b;
        one_chg = a_chg ^ b_chg;
        // forward: A edge leaves A differing from B; B edge leaves B equal to A
        up_c    = a_chg ? (a_s != st_q.b) : (b_s == st_q.a);

        cnt_pulse = active & one_chg & (x4 | a_chg);
        cnt_up    = up_c;
        idx_hit   = active & idx_s & ~st_q.idx & ~a_s & ~b_s;

        st_d     = st_q;
        st_d.a   = a_s;
        st_d.b   = b_s;
        st_d.idx = idx_s;
        if (active && one_chg) st_d.dir = up_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir = st_q.dir;

    // R4: a double change must not move the direction
    a_r4_invalid_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (a_chg && b_chg) |=> $stable(st_q.dir));

    // R1: a forward A rise (B low) yields forward direction
    a_r1_fwd_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (active && a_s && !st_q.a && !b_s && !st_q.b) |=> st_q.dir);
endmodule

// File: rtl/qpc_counter.sv
`timescale 1ns/1ps
module qpc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         idx_mode,
    input  logic         max_wrap,
    input  logic         cnt_pulse,
    input  logic         cnt_up,
    input  logic         idx_hit,
    input  logic         idx_clear_en,
    input  logic [W-1:0] max_count,
    input  logic         err_irq_mask,
    input  logic         err_clear,
    output logic [W-1:0] pos,
    output logic         err_flag,
    output logic         err_irq,
    output logic         idx_irq
);
    typedef struct packed {
        logic [W-1:0] pos;
        logic         flag;
        logic         eirq;
        logic         iirq;
    } cnt_t;

    cnt_t st_d, st_q;
    logic [W-1:0] inc_v, dec_v, max_p1;
    logic         err_ev;

    always_comb begin
        inc_v  = st_q.pos + W'(1);
        dec_v  = st_q.pos - W'(1);
        max_p1 = max_count + W'(1);
        err_ev = 1'b0;
        st_d   = st_q;

        if (active) begin
            if (idx_hit && idx_mode && idx_clear_en) begin
                st_d.pos = '0;
            end else if (cnt_pulse) begin
                if (cnt_up) begin
                    st_d.pos = (max_wrap && st_q.pos == max_count) ? '0 : inc_v;
                    err_ev   = idx_mode && (inc_v == max_p1);
                end else begin
                    st_d.pos = (max_wrap && st_q.pos == '0) ? max_count : dec_v;
                    err_ev   = idx_mode && (dec_v == '1);
                end
            end
        end

        if (err_ev)         st_d.flag = 1'b1;
        else if (err_clear) st_d.flag = 1'b0;
        st_d.eirq = err_ev & ~err_irq_mask;
        st_d.iirq = idx_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos      = st_q.pos;
    assign err_flag = st_q.flag;
    assign err_irq  = st_q.eirq;
    assign idx_irq  = st_q.iirq;

    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(st_q.pos));

    a_r8_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (active && max_wrap && cnt_pulse && cnt_up && st_q.pos == max_count) |=> (st_q.pos == '0));

    a_r8_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
        (active && max_wrap && cnt_pulse && !cnt_up && st_q.pos == '0) |=> (st_q.pos == $past(max_count)));

    a_r6_index_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (active && idx_hit && idx_mode && idx_clear_en) |=> (st_q.pos == '0));

    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !err_clear) |=> st_q.flag);

    a_r9_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.eirq |-> st_q.flag);

    a_r11_no_spurious_index: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_hit |=> !st_q.iirq);
endmodule

// File: rtl/quad_pos_counter.sv
`timescale 1ns/1ps
module quad_pos_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_index,
    input  logic [2:0]       cfg_mode,
    input  logic [CNT_W-1:0] cfg_max_count,
    input  logic             cfg_index_clear_en,
    input  logic             cfg_err_irq_mask,
    input  logic             cfg_dir_out_en,
    input  logic             err_flag_clear,
    output logic [CNT_W-1:0] pos_count,
    output logic             dir_status,
    output logic             dir_out,
    output logic             index_irq,
    output logic             error_irq,
    output logic             error_flag
);
    import qpc_pkg::*;

    localparam int N_IN = 3;

    mode_dec_t      md;
    logic [N_IN-1:0] raw_in, sync_in;
    logic cnt_pulse, cnt_up, idx_hit, dir_w;

    assign md     = decode_mode(cfg_mode);
    assign raw_in = {enc_index, enc_b, enc_a};

    qpc_sync #(.W(N_IN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (sync_in)
    );

    qpc_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_s       (sync_in[0]),
        .b_s       (sync_in[1]),
        .idx_s     (sync_in[2]),
        .active    (md.active),
        .x4        (md.x4),
        .cnt_pulse (cnt_pulse),
        .cnt_up    (cnt_up),
        .idx_hit   (idx_hit),
        .dir       (dir_w)
    );

    qpc_counter #(.W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (md.active),
        .idx_mode     (md.idx_mode),
        .max_wrap     (md.max_wrap),
        .cnt_pulse    (cnt_pulse),
        .cnt_up       (cnt_up),
        .idx_hit      (idx_hit),
        .idx_clear_en (cfg_index_clear_en),
        .max_count    (cfg_max_count),
        .err_irq_mask (cfg_err_irq_mask),
        .err_clear    (err_flag_clear),
        .pos          (pos_count),
        .err_flag     (error_flag),
        .err_irq      (error_irq),
        .idx_irq      (index_irq)
    );

    assign dir_status = dir_w;
    assign dir_out    = cfg_dir_out_en & dir_w;

    // R12: pin is never driven high while disabled
    a_r12_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dir_out_en |-> !dir_out);
endmodule

// File: tb/quad_pos_counter_test.sv
`timescale 1ns/1ps
module quad_pos_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_index = 1'b0;
    logic [2:0]  cfg_mode = 3'b110;
    logic [15:0] cfg_max_count = 16'h1000;
    logic        cfg_index_clear_en = 1'b0;
    logic        cfg_err_irq_mask = 1'b0;
    logic        cfg_dir_out_en = 1'b0;
    logic        err_flag_clear = 1'b0;
    logic [15:0] pos_count;
    logic        dir_status, dir_out, index_irq, error_irq, error_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [1:0] ab = 2'b00;
    logic seen_err, seen_idx;

    always #2.5 clk = ~clk;

    quad_pos_counter uut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_index(enc_index),
        .cfg_mode(cfg_mode), .cfg_max_count(cfg_max_count),
        .cfg_index_clear_en(cfg_index_clear_en), .cfg_err_irq_mask(cfg_err_irq_mask),
        .cfg_dir_out_en(cfg_dir_out_en), .err_flag_clear(err_flag_clear),
        .pos_count(pos_count), .dir_status(dir_status), .dir_out(dir_out),
        .index_irq(index_irq), .error_irq(error_irq), .error_flag(error_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] fwd_of(input logic [1:0] s);
        case (s)
            2'b00: return 2'b10;
            2'b10: return 2'b11;
            2'b11: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] rev_of(input logic [1:0] s);
        case (s)
            2'b00: return 2'b01;
            2'b01: return 2'b11;
            2'b11: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    // apply at a falling edge; pulses are due three falling edges later
    task automatic apply_ab(input logic [1:0] n);
        ab = n; enc_a = n[1]; enc_b = n[0];
        repeat (3) @(negedge clk);
        seen_err = error_irq; seen_idx = index_irq;
        @(negedge clk);
    endtask

    task automatic move(input bit fwd);
        apply_ab(fwd ? fwd_of(ab) : rev_of(ab));
    endtask

    task automatic pulse_index();
        enc_index = 1'b1;
        repeat (3) @(negedge clk);
        seen_err = error_irq; seen_idx = index_irq;
        enc_index = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_flag();
        err_flag_clear = 1'b1;
        @(negedge clk);
        err_flag_clear = 1'b0;
    endtask

    task automatic t_reset();
        chk("R13 reset pos", pos_count, 16'h0);
        chk("R9 reset flag", error_flag, 1'b0);
        chk("R11 reset index_irq", index_irq, 1'b0);
        chk("R9 reset error_irq", error_irq, 1'b0);
    endtask

    task automatic t_x4();
        cfg_mode = 3'b110;
        ab = 2'b10; enc_a = 1'b1; enc_b = 1'b0;
        repeat (2) @(negedge clk);
        chk("R13 count not yet moved", pos_count, 16'h0);
        @(negedge clk);
        chk("R13 count due at third edge", pos_count, 16'h1);
        @(negedge clk);
        for (int i = 0; i < 7; i++) move(1'b1);
        chk("R2 x4 forward eight edges", pos_count, 16'h8);
        chk("R1 forward direction", dir_status, 1'b1);
        for (int i = 0; i < 3; i++) move(1'b0);
        chk("R2 x4 reverse three edges", pos_count, 16'h5);
        chk("R1 reverse direction", dir_status, 1'b0);
    endtask

    task automatic t_x2();
        cfg_mode = 3'b100;
        move(1'b1);
        chk("R3 B edge ignored", pos_count, 16'h5);
        move(1'b1);
        chk("R3 A fall counts", pos_count, 16'h6);
        move(1'b1);
        chk("R3 B edge ignored again", pos_count, 16'h6);
        move(1'b1);
        chk("R3 A rise counts", pos_count, 16'h7);
        chk("R1 x2 forward dir", dir_status, 1'b1);
    endtask

    task automatic t_invalid();
        cfg_mode = 3'b110;
        apply_ab(2'b01);
        chk("R4 double change no count", pos_count, 16'h7);
        chk("R4 double change dir held", dir_status, 1'b1);
        apply_ab(2'b10);
        chk("R4 double change back no count", pos_count, 16'h7);
    endtask

    task automatic t_idle();
        cfg_mode = 3'b000;
        for (int i = 0; i < 3; i++) move(1'b1);
        chk("R5 idle holds count", pos_count, 16'h7);
        cfg_index_clear_en = 1'b1;
        pulse_index();
        chk("R5 idle no index irq", seen_idx, 1'b0);
        chk("R5 idle no clear", pos_count, 16'h7);
        cfg_index_clear_en = 1'b0;
    endtask

    task automatic t_index();
        cfg_mode = 3'b110;
        cfg_index_clear_en = 1'b0;
        pulse_index();
        chk("R11 index irq without clear", seen_idx, 1'b1);
        chk("R7 no clear when disabled", pos_count, 16'h7);
        chk("R11 irq is one cycle", index_irq, 1'b0);
        cfg_index_clear_en = 1'b1;
        pulse_index();
        chk("R11 index irq with clear", seen_idx, 1'b1);
        chk("R6 index clears count", pos_count, 16'h0);
        move(1'b1);
        pulse_index();
        chk("R6 index ignored with A high", seen_idx, 1'b0);
        chk("R6 count kept with A high", pos_count, 16'h1);
        move(1'b0);
        cfg_index_clear_en = 1'b0;
        move(1'b0);
        chk("R7 natural underflow", pos_count, 16'hFFFF);
        chk("R9 error irq on underflow", seen_err, 1'b1);
        chk("R11 no index irq on wrap", seen_idx, 1'b0);
        chk("R9 flag set on underflow", error_flag, 1'b1);
        move(1'b0);
        chk("R9 counting continues", pos_count, 16'hFFFE);
        chk("R9 no second error irq", seen_err, 1'b0);
        chk("R10 flag stays set", error_flag, 1'b1);
        clear_flag();
        chk("R10 flag cleared", error_flag, 1'b0);
    endtask

    task automatic t_maxwrap();
        cfg_mode = 3'b110;
        cfg_index_clear_en = 1'b1;
        while (ab != 2'b00) move(1'b1);
        pulse_index();
        chk("R6 count cleared before max test", pos_count, 16'h0);
        cfg_mode = 3'b111;
        cfg_max_count = 16'h0005;
        for (int i = 0; i < 5; i++) move(1'b1);
        chk("R8 reached max", pos_count, 16'h5);
        move(1'b1);
        chk("R8 up from max loads zero", pos_count, 16'h0);
        chk("R9 no error in max mode", seen_err, 1'b0);
        move(1'b0);
        chk("R8 down from zero loads max", pos_count, 16'h5);
        chk("R9 flag clear in max mode", error_flag, 1'b0);
    endtask

    task automatic t_error();
        cfg_mode = 3'b110;
        cfg_index_clear_en = 1'b1;
        while (ab != 2'b00) move(1'b1);
        pulse_index();
        clear_flag();
        cfg_max_count = 16'h0003;
        for (int i = 0; i < 3; i++) move(1'b1);
        chk("R9 no error below bound", error_flag, 1'b0);
        move(1'b1);
        chk("R9 error irq at max+1", seen_err, 1'b1);
        chk("R9 flag at max+1", error_flag, 1'b1);
        chk("R9 count reaches max+1", pos_count, 16'h4);
        move(1'b1);
        chk("R9 count continues past bound", pos_count, 16'h5);
        cfg_err_irq_mask = 1'b1;
        move(1'b0);
        pulse_index();
        clear_flag();
        for (int i = 0; i < 3; i++) move(1'b1);
        move(1'b1);
        chk("R9 masked error irq", seen_err, 1'b0);
        chk("R9 masked flag still set", error_flag, 1'b1);
        cfg_err_irq_mask = 1'b0;
    endtask

    task automatic t_dirpin();
        move(1'b1);
        cfg_dir_out_en = 1'b0;
        #1;
        chk("R12 pin low when disabled", dir_out, 1'b0);
        chk("R1 status forward", dir_status, 1'b1);
        cfg_dir_out_en = 1'b1;
        #1;
        chk("R12 pin follows status", dir_out, 1'b1);
        @(negedge clk);
        move(1'b0);
        chk("R12 pin follows reverse", dir_out, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_x4();
        t_x2();
        t_invalid();
        t_idle();
        t_index();
        t_maxwrap();
        t_error();
        t_dirpin();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule